// File: doc/BRIEF.md
# Bus-Activity Restarted Watchdog Timer

This block is a watchdog timer that a host keeps alive by producing ordinary traffic on a two-wire serial bus, not by toggling a dedicated kick pin. It samples the clock line and the data line, brings both into the local clock domain, and finds bus start and stop conditions. A start condition arms the restart. The next stop condition completes the sequence and restarts the timeout count. Both conditions must fall inside the current period.

A two-bit setting picks one of three timeout periods or turns the watchdog off. Time is measured in pulses of a one-millisecond tick input. When a period runs out with no restart, the block drives an active-low output pulse. The pulse is longer for the two slow settings and short for the fast one. In the first cycle of that pulse the block also gives a single-cycle fault strobe, which a separate fault-cause register uses to record a watchdog failure. When the pulse ends, a new period starts by itself. The setting is stored outside this block and arrives as an input.

The control path is a three-state machine. The states are OFF (disabled, output released), COUNT (timing a period) and PULSE (output active). The transitions are:
- enable: OFF to COUNT, when the setting changes to an enabled value.
- expire: COUNT to PULSE, on the tick that ends the period.
- reload: PULSE to COUNT, on the tick that ends the pulse.
- retime: COUNT or PULSE to COUNT with a zero count, when the setting changes to another enabled value.
- disable: COUNT or PULSE to OFF, when the setting changes to 11.

The bus detector is a two-state machine with states IDLE and ARMED. A start moves it to ARMED. A stop in ARMED issues a restart and returns it to IDLE.

Top module: `busact_wdog`

## Requirements
- R1: After reset the output `wdo_n` is high and `wdt_fault` is low. The setting is taken as 11 (disabled) until the first clock edge that samples the input.
- R2: The period setting is encoded as 00 = 1400 ticks, 01 = 200 ticks, 10 = 25 ticks and 11 = disabled. Counting from a restart, `wdo_n` goes low on the clock edge that takes the period's last tick.
- R3: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start followed by a stop restarts the count from zero, so a full period is then needed before expiry.
- R4: No restart is caused by a start with no later stop, by a stop with no start before it since the last restart, or by SDA changes while SCL is low.
- R5: The low pulse on `wdo_n` lasts 200 ticks for settings 00 and 01 and 25 ticks for setting 10.
- R6: `wdt_fault` is high for exactly one cycle: the first cycle in which `wdo_n` is low.
- R7: When the pulse ends, `wdo_n` returns high and a new full period starts with no restart needed.
- R8: A change of the setting to another enabled value restarts the count with the new period. A change to 11 releases `wdo_n` high one clock edge after it is sampled, and `wdo_n` stays high while the setting is 11.
- R9: A start and stop sequence during the low pulse has no effect. The pulse still ends after its full width, counted from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line, asynchronous |
| period_sel_i | input | 2 | Period setting: 00 long, 01 medium, 10 short, 11 off |
| wdo_n | output | 1 | Active-low watchdog output pulse |
| wdt_fault | output | 1 | One-cycle strobe when the watchdog expires |

## Verification
Each enabled setting is run with no bus traffic at all. This measures the tick count to expiry, the pulse width and the automatic reload, and tells the three periods and the two pulse widths apart. Random settings with a complete start-then-stop sequence placed at a random point in the period show that the count restarts, and not merely that expiry is late. A lone start, a lone stop, and SDA wiggled while SCL is low must each leave the remaining time unchanged, which separates a true start/stop pair from plain line activity. Restarts during the pulse, and changes of the setting in mid-period and in mid-pulse, check that a restart cannot shorten the pulse and that a setting change always restarts the count or disables the timer.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_COUNT = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_e;

    typedef enum logic {
        COND_IDLE  = 1'b0,
        COND_ARMED = 1'b1
    } cond_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int               WIDTH  = 2,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= INIT;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= INIT;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bwd_cond_det.sv
module bwd_cond_det
    import bwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic kick
);

    cond_state_e st_q, st_d;
    logic        scl_q, sda_q;
    logic        start_evt, stop_evt;

    // Both lines are compared with the previous synchronized sample.
    // SCL must be high in both samples, so an SDA change with SCL low
    // counts as neither condition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_evt = scl_q && scl_s && sda_q && !sda_s;
    assign stop_evt  = scl_q && scl_s && !sda_q && sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= COND_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            COND_IDLE:  if (start_evt) st_d = COND_ARMED;
            COND_ARMED: if (stop_evt)  st_d = COND_IDLE;
            default:    st_d = COND_IDLE;
        endcase
    end

    always_comb begin
        kick = (st_q == COND_ARMED) && stop_evt;
    end

endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
    import bwd_pkg::*;
#(
    parameter int LONG_MS   = 1400,
    parameter int MID_MS    = 200,
    parameter int SHORT_MS  = 25,
    parameter int WIDE_MS   = 200,
    parameter int NARROW_MS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       kick,
    input  logic [1:0] sel_i,
    output logic       wdo_n,
    output logic       fault
);

    localparam int MAX_MS = (LONG_MS > WIDE_MS) ? LONG_MS : WIDE_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    localparam logic [CNT_W-1:0] END_LONG   = CNT_W'(LONG_MS - 1);
    localparam logic [CNT_W-1:0] END_MID    = CNT_W'(MID_MS - 1);
    localparam logic [CNT_W-1:0] END_SHORT  = CNT_W'(SHORT_MS - 1);
    localparam logic [CNT_W-1:0] END_WIDE   = CNT_W'(WIDE_MS - 1);
    localparam logic [CNT_W-1:0] END_NARROW = CNT_W'(NARROW_MS - 1);

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       sel_q;
    logic             fault_q;
    logic             sel_chg;
    logic [CNT_W-1:0] period_end;
    logic [CNT_W-1:0] pulse_end;

    assign sel_chg = (sel_i != sel_q);

    always_comb begin
        unique case (sel_q)
            SEL_LONG:  period_end = END_LONG;
            SEL_MID:   period_end = END_MID;
            default:   period_end = END_SHORT;
        endcase
        pulse_end = (sel_q == SEL_SHORT) ? END_NARROW : END_WIDE;
    end

    // State register, count and registered fault strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= WD_OFF;
            cnt_q   <= '0;
            sel_q   <= SEL_OFF;
            fault_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_i;
            fault_q <= (st_q == WD_COUNT) && (st_d == WD_PULSE);
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            WD_OFF: begin
                if (sel_chg && (sel_i != SEL_OFF)) begin
                    st_d  = WD_COUNT;
                    cnt_d = '0;
                end
            end
            WD_COUNT: begin
                if (sel_chg) begin
                    st_d  = (sel_i == SEL_OFF) ? WD_OFF : WD_COUNT;
                    cnt_d = '0;
                end else if (kick) begin
                    cnt_d = '0;
                end else if (ms_tick) begin
                    if (cnt_q == period_end) begin
                        st_d  = WD_PULSE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            WD_PULSE: begin
                if (sel_chg) begin
                    st_d  = (sel_i == SEL_OFF) ? WD_OFF : WD_COUNT;
                    cnt_d = '0;
                end else if (ms_tick) begin
                    if (cnt_q == pulse_end) begin
                        st_d  = WD_COUNT;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = WD_OFF;
                cnt_d = '0;
            end
        endcase
    end

    // Output process.
    always_comb begin
        wdo_n = (st_q != WD_PULSE);
        fault = fault_q;
    end

endmodule

// File: rtl/busact_wdog.sv
module busact_wdog #(
    parameter int LONG_MS     = 1400,
    parameter int MID_MS      = 200,
    parameter int SHORT_MS    = 25,
    parameter int WIDE_MS     = 200,
    parameter int NARROW_MS   = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] period_sel_i,
    output logic       wdo_n,
    output logic       wdt_fault
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic             kick;

    bwd_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .INIT   ({LINES{1'b1}})
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    bwd_cond_det det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .kick  (kick)
    );

    bwd_ctrl #(
        .LONG_MS   (LONG_MS),
        .MID_MS    (MID_MS),
        .SHORT_MS  (SHORT_MS),
        .WIDE_MS   (WIDE_MS),
        .NARROW_MS (NARROW_MS)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .kick    (kick),
        .sel_i   (period_sel_i),
        .wdo_n   (wdo_n),
        .fault   (wdt_fault)
    );

endmodule

// File: rtl/busact_wdog_chk.sv
module busact_wdog_chk #(
    parameter int PULSE_MAX = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ms_tick,
    input logic [1:0] period_sel_i,
    input logic       wdo_n,
    input logic       wdt_fault
);

    localparam int LW = $clog2(PULSE_MAX + 2);

    logic [LW-1:0] low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_ticks <= '0;
        else if (wdo_n)             low_ticks <= '0;
        else if (ms_tick)           low_ticks <= low_ticks + 1'b1;
    end

    // R6: the strobe marks the falling edge of the output
    assert_fault_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> wdt_fault);

    // R6: the strobe only while the output is low
    assert_fault_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fault |-> !wdo_n);

    // R6: single-cycle strobe
    assert_fault_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fault |=> !wdt_fault);

    // R8: disabled setting releases the output
    assert_off_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_sel_i) == 2'b11) |-> wdo_n);

    // R5: no pulse longer than the widest width
    assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= LW'(PULSE_MAX));

endmodule

bind busact_wdog busact_wdog_chk #(
    .PULSE_MAX (WIDE_MS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .period_sel_i (period_sel_i),
    .wdo_n        (wdo_n),
    .wdt_fault    (wdt_fault)
);

// File: tb/busact_wdog_tb_top.sv
`timescale 1ns/1ps
module busact_wdog_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [1:0] sel = 2'b11;
    logic       wdo_n;
    logic       wdt_fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    busact_wdog dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .scl_i        (scl),
        .sda_i        (sda),
        .period_sel_i (sel),
        .wdo_n        (wdo_n),
        .wdt_fault    (wdt_fault)
    );

    function automatic int period_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1400;
            2'b01:   return 200;
            default: return 25;
        endcase
    endfunction

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'b10) ? 25 : 200;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int k);
        ms_tick = 1'b1;
        repeat (k) @(negedge clk);
        ms_tick = 1'b0;
    endtask

    // Ticks every cycle; returns the number of ticks until wdo_n is seen low.
    task automatic run_until_low(output int n);
        n = 0;
        ms_tick = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            n++;
            if (!wdo_n) break;
        end
    endtask

    // Called with wdo_n low; counts low samples until released.
    task automatic run_while_low(output int m);
        m = 1;
        ms_tick = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (wdo_n) break;
            m++;
        end
    endtask

    task automatic bus_start();
        scl = 1'b1; sda = 1'b1; idle(4);
        sda = 1'b0; idle(4);
        scl = 1'b0; idle(4);
    endtask

    task automatic bus_stop();
        scl = 1'b0; idle(4);
        sda = 1'b0; idle(4);
        scl = 1'b1; idle(4);
        sda = 1'b1; idle(4);
    endtask

    task automatic low_wiggle();
        scl = 1'b0; idle(4);
        for (int i = 0; i < 4; i++) begin
            sda = ~sda; idle(3);
        end
        sda = 1'b1; idle(3);
        scl = 1'b1; idle(4);
    endtask

    task automatic set_sel(input logic [1:0] s);
        ms_tick = 1'b0;
        sel = s;
        idle(4);
    endtask

    initial begin
        int n, m, k;
        logic [1:0] s;
        void'($urandom(32'h1b2c));

        idle(3);
        check(wdo_n === 1'b1, "R1 wdo_n in reset", wdo_n, 1);
        check(wdt_fault === 1'b0, "R1 fault in reset", wdt_fault, 0);
        rst_n = 1'b1;
        idle(2);

        // R8: disabled, output held high over many ticks
        begin
            bit stayed = 1'b1;
            ms_tick = 1'b1;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                if (!wdo_n) stayed = 1'b0;
            end
            ms_tick = 1'b0;
            check(stayed, "R8 disabled holds wdo_n high", stayed, 1);
        end

        // Directed sweep of all enabled settings: R2, R5, R6, R7
        for (int j = 0; j < 3; j++) begin
            s = (j == 0) ? 2'b10 : (j == 1) ? 2'b01 : 2'b00;
            set_sel(s);
            check(wdo_n === 1'b1, "R8 change releases output", wdo_n, 1);
            run_until_low(n);
            check(n == period_of(s), "R2 period length", n, period_of(s));
            check(wdt_fault === 1'b1, "R6 fault on first low cycle", wdt_fault, 1);
            run_while_low(m);
            check(m == width_of(s), "R5 pulse width", m, width_of(s));
            run_until_low(n);
            check(n == period_of(s), "R7 automatic reload period", n, period_of(s));
            ms_tick = 1'b0;
        end

        // R3: random restarts at random points
        for (int it = 0; it < 6; it++) begin
            s = 2'($urandom % 3);
            set_sel(2'b11);
            set_sel(s);
            k = 1 + int'($urandom % (period_of(s) - 1));
            tick_n(k);
            bus_start();
            bus_stop();
            check(wdo_n === 1'b1, "R3 no expiry during restart", wdo_n, 1);
            run_until_low(n);
            check(n == period_of(s), "R3 restart gives full period", n, period_of(s));
            ms_tick = 1'b0;
        end

        // R4: start alone does not restart
        set_sel(2'b11);
        set_sel(2'b10);
        tick_n(10);
        bus_start();
        run_until_low(n);
        check(n == 15, "R4 start alone ignored", n, 15);
        ms_tick = 1'b0;
        set_sel(2'b11);
        bus_stop();   // completes the pending pair while disabled

        // R4: stop alone and SDA wiggle with SCL low do not restart
        set_sel(2'b10);
        tick_n(5);
        bus_stop();
        tick_n(5);
        low_wiggle();
        run_until_low(n);
        check(n == 15, "R4 stop alone and low-SCL wiggle ignored", n, 15);
        ms_tick = 1'b0;

        // R9: restart during the pulse has no effect
        set_sel(2'b11);
        set_sel(2'b10);
        run_until_low(n);
        tick_n(10);
        bus_start();
        bus_stop();
        check(wdo_n === 1'b0, "R9 pulse held through restart", wdo_n, 0);
        run_while_low(m);
        check(m == 15, "R9 pulse width unchanged", m, 15);
        ms_tick = 1'b0;

        // R8: period change mid-count restarts with new period
        set_sel(2'b11);
        set_sel(2'b00);
        tick_n(700);
        set_sel(2'b10);
        run_until_low(n);
        check(n == 25, "R8 new period after change", n, 25);
        ms_tick = 1'b0;

        // R8: disable during the pulse releases output next edge
        sel = 2'b11;
        @(negedge clk);
        check(wdo_n === 1'b1, "R8 disable during pulse", wdo_n, 1);
        idle(4);

        finish_run();
    end

endmodule